// File: doc/BRIEF.md
# Opcode-Selected Integer ALU with Flags

This block is a purely combinational integer unit of parameterised width, 64 bits by default. A 4-bit operation code picks one of twelve functions on two operands and a carry input. The functions are increment, decrement, add with carry, subtract with borrow, the bitwise logic operations, one-position logical shifts and one-position rotates. The block reports carry, signed overflow, zero and negative flags alongside the result. All four carry-chained operations share one lookahead adder. Subtraction feeds that adder with the inverted B operand.

The output is twice the operand width. For the twelve ALU functions, the result sits in the lower half. Two further codes pass results computed elsewhere straight to the output: a full-width product, or a quotient and remainder pair. The multiply and divide engines live outside the block and deliver their results on input ports. The two remaining codes are idle and produce zero.

Top module: `opsel_alu`

## Requirements
- R1: Code 0000 gives A+1, with carry set only when A is all ones. Code 0011 gives A-1, with carry clear only when A is zero.
- R2: Code 0001 gives A+B+cin. The carry flag is the carry out of the top bit.
- R3: Code 0010 gives A-B-cin in two's complement. The carry flag is 1 when no borrow occurs, that is, when A is at least B+cin as unsigned numbers.
- R4: Overflow for codes 0000, 0001 and 0011 is set when the two addends share a sign bit and the result's sign differs from it. For code 0010 it is set when A and B differ in sign and the result's sign differs from A's.
- R5: Codes 0100, 0101, 0110 and 0111 give A AND B, A OR B, A XOR B and NOT A, with carry and overflow both 0.
- R6: Code 1000 shifts A right by one and code 1001 shifts A left by one, filling the vacated bit with zero. Carry holds the bit that leaves A. Overflow is 0.
- R7: Code 1010 rotates A right by one and code 1011 rotates A left by one. Carry holds the bit that wraps around. Overflow is 0.
- R8: For codes 0000 to 1011, the zero flag is 1 exactly when the lower result half is all zeros, and the negative flag equals the top bit of the lower half.
- R9: Code 1100 drives the whole product input onto the output unchanged.
- R10: Code 1101 puts the quotient input in the upper output half and the remainder input in the lower output half.
- R11: For codes 0000 to 1011, the upper output half is zero.
- R12: Codes 1110 and 1111 give an all-zero output. For codes 1100 to 1111, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_op | input | 4 | Operation code |
| i_a | input | WIDTH | First operand |
| i_b | input | WIDTH | Second operand |
| i_cin | input | 1 | Carry/borrow input for codes 0001 and 0010 |
| i_prod | input | 2*WIDTH | Product from the external multiplier |
| i_quot | input | WIDTH | Quotient from the external divider |
| i_rem | input | WIDTH | Remainder from the external divider |
| o_result | output | 2*WIDTH | Packed result |
| o_carry | output | 1 | Carry / no-borrow / shifted-out bit |
| o_ovf | output | 1 | Signed overflow |
| o_zero | output | 1 | Lower result half is zero |
| o_neg | output | 1 | Top bit of lower result half |

## Verification
The block holds no state, so any fault shows at the ports in the same evaluation as the stimulus that reaches it. A broken group carry in the lookahead adder appears as a wrong sum only for operands whose carry crosses a group boundary. For that reason, a 4-bit instance is swept over every operand, carry and code combination. A 64-bit instance is then driven with sign-edge and all-ones patterns. A misrouted packing select or flag qualifier shows up immediately on the upper output half or on the flags for the packing and idle codes.

// File: rtl/opsel_alu_pkg.sv
// Package: shared operation codes and helpers for the opcode-selected ALU.
// Assumes the 4-bit code space is fully decoded; two codes are reserved idle.
package opsel_alu_pkg;

    typedef enum logic [3:0] {
        OP_INC  = 4'h0,
        OP_ADC  = 4'h1,
        OP_SBB  = 4'h2,
        OP_DEC  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOT  = 4'h7,
        OP_SHR  = 4'h8,
        OP_SHL  = 4'h9,
        OP_ROR  = 4'hA,
        OP_ROL  = 4'hB,
        OP_MUL  = 4'hC,
        OP_DIV  = 4'hD,
        OP_IDL0 = 4'hE,
        OP_IDL1 = 4'hF
    } alu_op_e;

    // True for the four operations that run through the adder.
    function automatic logic is_carry_op(alu_op_e op);
        return (op == OP_INC) || (op == OP_ADC) || (op == OP_SBB) || (op == OP_DEC);
    endfunction

    // True for logic, shift and rotate operations.
    function automatic logic is_bit_op(alu_op_e op);
        return (op >= OP_AND) && (op <= OP_ROL);
    endfunction

endpackage

// File: rtl/alu_cla_adder.sv
// Module: grouped carry-lookahead adder.
// Bits are split into groups of GRP. Each group forms its own generate and
// propagate terms, and the group carries chain from group to group.
// Assumes WIDTH is a multiple of GRP.
module alu_cla_adder #(
    parameter int WIDTH = 64,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0] i_x,
    input  logic [WIDTH-1:0] i_y,
    input  logic             i_c,
    output logic [WIDTH-1:0] o_sum,
    output logic             o_cout
);
    localparam int NGRP = WIDTH / GRP;

    logic [WIDTH-1:0] gen_b;
    logic [WIDTH-1:0] prp_b;
    logic [NGRP:0]    grp_c;

    assign gen_b    = i_x & i_y;
    assign prp_b    = i_x ^ i_y;
    assign grp_c[0] = i_c;
    assign o_cout   = grp_c[NGRP];

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic [GRP-1:0] bit_c;
        logic           grp_g;
        logic           grp_p;

        // Purpose: carries into each bit of this group from the group carry-in.
        always_comb begin
            bit_c[0] = grp_c[k];
            for (int i = 0; i < GRP - 1; i++) begin
                bit_c[i+1] = gen_b[k*GRP+i] | (prp_b[k*GRP+i] & bit_c[i]);
            end
        end

        // Purpose: group-level generate and propagate terms.
        always_comb begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            for (int i = 0; i < GRP; i++) begin
                grp_g = gen_b[k*GRP+i] | (prp_b[k*GRP+i] & grp_g);
                grp_p = grp_p & prp_b[k*GRP+i];
            end
        end

        assign grp_c[k+1]            = grp_g | (grp_p & grp_c[k]);
        assign o_sum[k*GRP +: GRP]   = prp_b[k*GRP +: GRP] ^ bit_c;
    end

endmodule

// File: rtl/alu_arith.sv
// Module: carry-chained arithmetic for increment, add-with-carry,
// subtract-with-borrow and decrement.
// It selects the second addend and the carry-in, and then runs one shared
// lookahead adder. Its outputs only mean something for those four codes.
module alu_arith
    import opsel_alu_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int GRP   = 4
) (
    input  alu_op_e          i_op,
    input  logic [WIDTH-1:0] i_a,
    input  logic [WIDTH-1:0] i_b,
    input  logic             i_cin,
    output logic [WIDTH-1:0] o_sum,
    output logic             o_cout,
    output logic             o_ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] add_y;
    logic             add_c;

    // Purpose: choose the second addend and carry-in for each operation.
    always_comb begin
        add_y = '0;
        add_c = 1'b0;
        case (i_op)
            OP_INC: begin add_y = '0;   add_c = 1'b1;   end
            OP_ADC: begin add_y = i_b;  add_c = i_cin;  end
            OP_SBB: begin add_y = ~i_b; add_c = ~i_cin; end
            OP_DEC: begin add_y = '1;   add_c = 1'b0;   end
            default: begin add_y = '0;  add_c = 1'b0;   end
        endcase
    end

    alu_cla_adder #(.WIDTH(WIDTH), .GRP(GRP)) u_adder (
        .i_x    (i_a),
        .i_y    (add_y),
        .i_c    (add_c),
        .o_sum  (o_sum),
        .o_cout (o_cout)
    );

    // Purpose: signed overflow when same-sign addends give a different sign.
    always_comb begin
        o_ovf = (i_a[MSB] == add_y[MSB]) && (o_sum[MSB] != i_a[MSB]);
    end

endmodule

// File: rtl/alu_bitops.sv
// Module: bitwise logic, one-place shifts and one-place rotates.
// Carry carries the bit that leaves A on a shift or a rotate, and is 0 for
// the logic operations. Assumes WIDTH >= 2.
module alu_bitops
    import opsel_alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  alu_op_e          i_op,
    input  logic [WIDTH-1:0] i_a,
    input  logic [WIDTH-1:0] i_b,
    output logic [WIDTH-1:0] o_res,
    output logic             o_carry
);
    localparam int MSB = WIDTH - 1;

    // Purpose: compute the bitwise, shift or rotate result and out-bit.
    always_comb begin
        o_res   = '0;
        o_carry = 1'b0;
        case (i_op)
            OP_AND: o_res = i_a & i_b;
            OP_OR:  o_res = i_a | i_b;
            OP_XOR: o_res = i_a ^ i_b;
            OP_NOT: o_res = ~i_a;
            OP_SHR: begin o_res = {1'b0, i_a[MSB:1]};   o_carry = i_a[0];   end
            OP_SHL: begin o_res = {i_a[MSB-1:0], 1'b0}; o_carry = i_a[MSB]; end
            OP_ROR: begin o_res = {i_a[0], i_a[MSB:1]}; o_carry = i_a[0];   end
            OP_ROL: begin o_res = {i_a[MSB-1:0], i_a[MSB]}; o_carry = i_a[MSB]; end
            default: begin o_res = '0; o_carry = 1'b0; end
        endcase
    end

endmodule

// File: rtl/alu_pack.sv
// Module: forms the double-width output.
// Passes the product through, places the quotient above the remainder, or
// zero-extends the ALU result, depending on the code.
module alu_pack
    import opsel_alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  alu_op_e            i_op,
    input  logic [WIDTH-1:0]   i_alu,
    input  logic [2*WIDTH-1:0] i_prod,
    input  logic [WIDTH-1:0]   i_quot,
    input  logic [WIDTH-1:0]   i_rem,
    output logic [2*WIDTH-1:0] o_packed
);
    // Purpose: steer the selected source onto the wide output.
    always_comb begin
        case (i_op)
            OP_MUL:  o_packed = i_prod;
            OP_DIV:  o_packed = {i_quot, i_rem};
            default: o_packed = {{WIDTH{1'b0}}, i_alu};
        endcase
    end

endmodule

// File: rtl/opsel_alu.sv
// Module: top of the opcode-selected integer ALU.
// It is fully combinational and holds no state, so it has no clock or reset.
// It merges the arithmetic and bitwise paths, forms the flags and packs the
// wide output. Codes 1100 to 1111 clear every flag, and 1110/1111 give zero.
module opsel_alu
    import opsel_alu_pkg::*;
#(
    parameter int WIDTH     = 64,
    parameter int CLA_GROUP = 4
) (
    input  logic [3:0]         i_op,
    input  logic [WIDTH-1:0]   i_a,
    input  logic [WIDTH-1:0]   i_b,
    input  logic               i_cin,
    input  logic [2*WIDTH-1:0] i_prod,
    input  logic [WIDTH-1:0]   i_quot,
    input  logic [WIDTH-1:0]   i_rem,
    output logic [2*WIDTH-1:0] o_result,
    output logic               o_carry,
    output logic               o_ovf,
    output logic               o_zero,
    output logic               o_neg
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] ar_sum;
    logic             ar_cout;
    logic             ar_ovf;
    logic [WIDTH-1:0] bo_res;
    logic             bo_carry;
    logic [WIDTH-1:0] alu_res;

    assign op = alu_op_e'(i_op);

    alu_arith #(.WIDTH(WIDTH), .GRP(CLA_GROUP)) u_arith (
        .i_op   (op),
        .i_a    (i_a),
        .i_b    (i_b),
        .i_cin  (i_cin),
        .o_sum  (ar_sum),
        .o_cout (ar_cout),
        .o_ovf  (ar_ovf)
    );

    alu_bitops #(.WIDTH(WIDTH)) u_bitops (
        .i_op    (op),
        .i_a     (i_a),
        .i_b     (i_b),
        .o_res   (bo_res),
        .o_carry (bo_carry)
    );

    // Purpose: pick the active path and produce carry and overflow.
    always_comb begin
        if (is_carry_op(op)) begin
            alu_res = ar_sum;
            o_carry = ar_cout;
            o_ovf   = ar_ovf;
        end else if (is_bit_op(op)) begin
            alu_res = bo_res;
            o_carry = bo_carry;
            o_ovf   = 1'b0;
        end else begin
            alu_res = '0;
            o_carry = 1'b0;
            o_ovf   = 1'b0;
        end
    end

    // Purpose: zero and negative flags, qualified to the twelve ALU codes.
    always_comb begin
        o_zero = (is_carry_op(op) || is_bit_op(op)) && (alu_res == '0);
        o_neg  = alu_res[MSB];
    end

    alu_pack #(.WIDTH(WIDTH)) u_pack (
        .i_op     (op),
        .i_alu    (alu_res),
        .i_prod   (i_prod),
        .i_quot   (i_quot),
        .i_rem    (i_rem),
        .o_packed (o_result)
    );

endmodule

// File: rtl/opsel_alu_chk.sv
// Module: port-level checker for opsel_alu, attached with bind.
// Uses immediate assertions only, because the block has no clock.
module opsel_alu_chk #(
    parameter int WIDTH = 64
) (
    input logic [3:0]         i_op,
    input logic [WIDTH-1:0]   i_a,
    input logic [2*WIDTH-1:0] i_prod,
    input logic [WIDTH-1:0]   i_quot,
    input logic [WIDTH-1:0]   i_rem,
    input logic [2*WIDTH-1:0] o_result,
    input logic               o_carry,
    input logic               o_ovf,
    input logic               o_zero,
    input logic               o_neg
);
    localparam int MSB = WIDTH - 1;

    // Purpose: relate packed output and flags to the code and inputs.
    always_comb begin
        if (i_op < 4'd12) begin
            a_r11_upper_zero: assert (o_result[2*WIDTH-1:WIDTH] == '0)
                else $error("upper half not zero");
            a_r8_zero_flag: assert (o_zero == (o_result[MSB:0] == '0))
                else $error("zero flag disagrees with result");
            a_r8_neg_flag: assert (o_neg == o_result[MSB])
                else $error("negative flag disagrees with result");
        end
        if (i_op == 4'd12) begin
            a_r9_product_pass: assert (o_result == i_prod)
                else $error("product not passed");
        end
        if (i_op == 4'd13) begin
            a_r10_quot_rem: assert (o_result == {i_quot, i_rem})
                else $error("quotient/remainder misplaced");
        end
        if (i_op >= 4'd12) begin
            a_r12_flags_clear: assert (!o_carry && !o_ovf && !o_zero && !o_neg)
                else $error("flags not cleared");
        end
        if (i_op >= 4'd14) begin
            a_r12_idle_zero: assert (o_result == '0)
                else $error("idle code output not zero");
        end
        if (i_op >= 4'd4 && i_op <= 4'd11) begin
            a_r5_no_overflow: assert (!o_ovf)
                else $error("overflow on non-arithmetic code");
        end
        if (i_op == 4'd8 || i_op == 4'd10) begin
            a_r6_right_out_bit: assert (o_carry == i_a[0])
                else $error("right shift/rotate carry wrong");
        end
        if (i_op == 4'd10) begin
            a_r7_ror_wrap: assert (o_result[MSB] == i_a[0])
                else $error("rotate right did not wrap");
        end
    end

endmodule

bind opsel_alu opsel_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .i_op     (i_op),
    .i_a      (i_a),
    .i_prod   (i_prod),
    .i_quot   (i_quot),
    .i_rem    (i_rem),
    .o_result (o_result),
    .o_carry  (o_carry),
    .o_ovf    (o_ovf),
    .o_zero   (o_zero),
    .o_neg    (o_neg)
);

// File: tb/opsel_alu_tb.sv
// Bench: exhaustive sweep of a 4-bit instance and patterned sweep of a 64-bit one.
module opsel_alu_tb;

    typedef struct packed {
        logic [63:0] res;
        logic        c;
        logic        v;
        logic        z;
        logic        ng;
    } exp_t;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    int   n_cmp = 0;
    int   n_bad = 0;
    logic done  = 1'b0;

    always #10 clk = ~clk;

    // Small instance
    logic [3:0]  s_op = '0;
    logic [3:0]  s_a = '0, s_b = '0, s_quot = '0, s_rem = '0;
    logic        s_cin = 1'b0;
    logic [7:0]  s_prod = '0, s_res;
    logic        s_c, s_v, s_z, s_n;

    // Wide instance
    logic [3:0]   w_op = '0;
    logic [63:0]  w_a = '0, w_b = '0, w_quot = '0, w_rem = '0;
    logic         w_cin = 1'b0;
    logic [127:0] w_prod = '0, w_res;
    logic         w_c, w_v, w_z, w_n;

    opsel_alu #(.WIDTH(4), .CLA_GROUP(2)) u_dut (
        .i_op(s_op), .i_a(s_a), .i_b(s_b), .i_cin(s_cin), .i_prod(s_prod),
        .i_quot(s_quot), .i_rem(s_rem), .o_result(s_res), .o_carry(s_c),
        .o_ovf(s_v), .o_zero(s_z), .o_neg(s_n)
    );

    opsel_alu #(.WIDTH(64), .CLA_GROUP(4)) u_dut_wide (
        .i_op(w_op), .i_a(w_a), .i_b(w_b), .i_cin(w_cin), .i_prod(w_prod),
        .i_quot(w_quot), .i_rem(w_rem), .o_result(w_res), .o_carry(w_c),
        .o_ovf(w_v), .o_zero(w_z), .o_neg(w_n)
    );

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0, 4'd3:               return "R1";
            4'd1:                     return "R2";
            4'd2:                     return "R3";
            4'd4, 4'd5, 4'd6, 4'd7:   return "R5";
            4'd8, 4'd9:               return "R6";
            4'd10, 4'd11:             return "R7";
            4'd12:                    return "R9";
            4'd13:                    return "R10";
            default:                  return "R12";
        endcase
    endfunction

    // Reference model written from the requirements, at width n.
    function automatic exp_t model(int n, logic [3:0] op, logic [63:0] a_in,
                                   logic [63:0] b_in, logic cin);
        logic [63:0] m, sb, a, b;
        logic [64:0] wide;
        exp_t e;
        m  = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        sb = 64'd1 << (n - 1);
        a  = a_in & m;
        b  = b_in & m;
        e  = '0;
        case (op)
            4'd0: begin e.res = (a + 64'd1) & m; e.c = (a == m); e.v = (a == (m >> 1)); end
            4'd1: begin
                wide  = {1'b0, a} + {1'b0, b} + 65'(cin);
                e.res = wide[63:0] & m;
                e.c   = wide[n];
                e.v   = ((a & sb) == (b & sb)) && ((e.res & sb) != (a & sb));
            end
            4'd2: begin
                e.res = (a - b - 64'(cin)) & m;
                e.c   = ({1'b0, a} >= ({1'b0, b} + 65'(cin)));
                e.v   = ((a & sb) != (b & sb)) && ((e.res & sb) != (a & sb));
            end
            4'd3: begin e.res = (a - 64'd1) & m; e.c = (a != 0); e.v = (a == sb); end
            4'd4: e.res = a & b;
            4'd5: e.res = a | b;
            4'd6: e.res = a ^ b;
            4'd7: e.res = ~a & m;
            4'd8: begin e.res = a >> 1; e.c = a[0]; end
            4'd9: begin e.res = (a << 1) & m; e.c = ((a & sb) != 0); end
            4'd10: begin e.res = (a >> 1) | (a[0] ? sb : 64'd0); e.c = a[0]; end
            4'd11: begin
                e.res = ((a << 1) & m) | (((a & sb) != 0) ? 64'd1 : 64'd0);
                e.c   = ((a & sb) != 0);
            end
            default: return e;
        endcase
        e.z  = (e.res == 0);
        e.ng = ((e.res & sb) != 0);
        return e;
    endfunction

    task automatic cmp1(string tag, string what, logic [127:0] got, logic [127:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check(int n, logic [3:0] op, logic [63:0] a, logic [63:0] b,
                         logic cin, logic [127:0] prod, logic [63:0] quot,
                         logic [63:0] rem, logic [127:0] g_res, logic g_c,
                         logic g_v, logic g_z, logic g_n);
        exp_t         e;
        logic [63:0]  m;
        logic [127:0] m2, xr;
        string        t;
        e  = model(n, op, a, b, cin);
        m  = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        m2 = (n == 64) ? '1 : ((128'd1 << (2 * n)) - 128'd1);
        t  = req_of(op);
        if (op == 4'd12)      xr = prod & m2;
        else if (op == 4'd13) xr = ({64'd0, quot & m} << n) | {64'd0, rem & m};
        else                  xr = {64'd0, e.res};
        cmp1(t, "result", g_res, xr);
        if (op < 4'd12) cmp1("R11", "upper half", g_res >> n, 128'd0);
        cmp1(t, "carry", 128'(g_c), 128'(e.c));
        cmp1((op <= 4'd3) ? "R4" : t, "overflow", 128'(g_v), 128'(e.v));
        cmp1((op < 4'd12) ? "R8" : "R12", "zero", 128'(g_z), 128'(e.z));
        cmp1((op < 4'd12) ? "R8" : "R12", "negative", 128'(g_n), 128'(e.ng));
    endtask

    function automatic logic [63:0] pat(int i);
        case (i)
            0:       return 64'h0;
            1:       return '1;
            2:       return 64'h8000_0000_0000_0001;
            3:       return 64'h7FFF_FFFF_FFFF_FFFF;
            4:       return 64'h0123_4567_89AB_CDEF;
            default: return 64'h8000_0000_0000_0000;
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Purpose: main stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Output seen while reset is held: code 0000 on zero gives 1 (R1).
        check(64, 4'd0, 64'd0, 64'd0, 1'b0, 128'd0, 64'd0, 64'd0, w_res, w_c, w_v, w_z, w_n);
        rst_n = 1'b1;
        // Exhaustive sweep of the 4-bit instance over all codes (R1 to R12).
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        @(posedge clk);
                        s_op   = 4'(op);
                        s_a    = 4'(a);
                        s_b    = 4'(b);
                        s_cin  = 1'(c);
                        s_prod = 8'({4'(a), 4'(b)}) ^ 8'hA5;
                        s_quot = 4'(b) ^ 4'h3;
                        s_rem  = 4'(a) ^ 4'h9;
                        @(negedge clk);
                        check(4, s_op, 64'(s_a), 64'(s_b), s_cin, 128'(s_prod),
                              64'(s_quot), 64'(s_rem), 128'(s_res), s_c, s_v, s_z, s_n);
                    end
                end
            end
        end
        // Patterned sweep of the 64-bit instance: sign edges and all-ones.
        for (int op = 0; op < 16; op++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    for (int c = 0; c < 2; c++) begin
                        @(posedge clk);
                        w_op   = 4'(op);
                        w_a    = pat(ia);
                        w_b    = pat(ib);
                        w_cin  = 1'(c);
                        w_prod = {pat(ia) ^ pat(ib), pat(ib)};
                        w_quot = ~pat(ia);
                        w_rem  = pat(ib);
                        @(negedge clk);
                        check(64, w_op, w_a, w_b, w_cin, w_prod, w_quot, w_rem,
                              w_res, w_c, w_v, w_z, w_n);
                    end
                end
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    // Purpose: end a hung run as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule